// File: doc/BRIEF.md
# Split-Chain Parallel Multiplier

This block multiplies two 16-bit operands in a single pass and returns the full 32-bit product. Each operand has its own control bit. The bit selects whether the operand is read as unsigned or as two's complement, so one array serves all four combinations of operand types. Each operand is first extended by one bit according to its control bit. The block then forms sign-inverted partial products over the widened operands and adds one correction constant. Because of this, no separate signed path is needed.

The partial-product rows do not reduce in one long carry-save column. They are dealt into two interleaved chains. The rows with even index feed one chain and the rows with odd index feed the other, and the two chains reduce side by side. Only at the bottom are their two sum/carry pairs compressed into a single pair, which a carry-propagate adder turns into the product. This roughly halves the adder depth of a column. With 16-bit operands, a column passes through seven chain stages and two merge stages.

The arithmetic core is purely combinational. Parameters can place a register in front of the core, behind it, or both. A valid bit travels alongside the data so that the caller sees when a result arrives.

Top module: `oem_mult`

## Requirements
- R1: With both control bits at 0 (0 = unsigned, 1 = two's complement), `product` equals the unsigned product of `opd_a` and `opd_b` as a 32-bit value.
- R2: With both control bits at 1, `product` equals the low 32 bits of the two's-complement product.
- R3: With exactly one control bit at 1, the marked operand is read as two's complement and the other as unsigned, and `product` is the low 32 bits of the exact result.
- R4: For the operands 0, 1, 0xFFFF, 0x8000 and 0x7FFF, in every pairing and every mode, the product is exact. For example, signed 0x8000 times 0x8000 gives 0x40000000, and unsigned 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R5: `out_valid` rises exactly IN_REG+OUT_REG cycles after the cycle in which `in_valid` was sampled high (2 by default). Results come out in the order the operations were issued.
- R6: While `out_valid` is low, `product` keeps the last result. Operands and control bits presented with `in_valid` low have no effect on any later output.
- R7: While reset is asserted, and until the first result arrives, `out_valid` is 0 and `product` is 0.
- R8: Row 0 and the other even-indexed rows reduce in one carry-save chain. The odd-indexed rows plus the correction constant reduce in a second chain. The four vectors at the bottom of the two chains sum, modulo 2^32, to the product. No column passes through more than nine adder stages at OPW=16.
- R9: A new operation can be issued in every cycle, and back-to-back operations each produce their own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and control bits are valid this cycle |
| opd_a | input | OPW | First operand |
| opd_b | input | OPW | Second operand |
| a_signed | input | 1 | 1: `opd_a` is two's complement; 0: unsigned |
| b_signed | input | 1 | 1: `opd_b` is two's complement; 0: unsigned |
| out_valid | output | 1 | `product` holds a new result this cycle |
| product | output | 2*OPW | Full-width product |

## Verification
The bench builds the block with its defaults: OPW=16 and both register stages present. That gives a nine-row even chain, an eight-row odd chain and a two-cycle latency. The widths let the corner operands drive the sign-inversion terms and the correction constant to the edge of the 32-bit result in all four modes. The two register stages let the bench check latency, ordering in back-to-back streams, and the hold of `product` across idle cycles that carry random data.

// File: rtl/oem_pkg.sv
package oem_pkg;

  // Count of partial-product rows that fall to the chain holding row 0.
  function automatic int even_row_count(input int n_rows);
    return (n_rows + 1) / 2;
  endfunction

  // Count of partial-product rows that fall to the other chain.
  function automatic int odd_row_count(input int n_rows);
    return n_rows / 2;
  endfunction

endpackage

// File: rtl/oem_ppgen.sv
module oem_ppgen #(
  parameter  int OPW = 16,
  localparam int NR  = OPW + 1,
  localparam int PW  = 2 * OPW
) (
  input  logic [OPW-1:0]         a_i,
  input  logic [OPW-1:0]         b_i,
  input  logic                   a_sgn_i,
  input  logic                   b_sgn_i,
  output logic [NR-1:0][PW-1:0]  rows_o
);

  // Operands widened by one bit so that every mode becomes a signed product.
  logic [NR-1:0] ax;
  logic [NR-1:0] bx;

  assign ax = {a_sgn_i & a_i[OPW-1], a_i};
  assign bx = {b_sgn_i & b_i[OPW-1], b_i};

  // Row r holds ax * bx[r] shifted left by r. A term is inverted when exactly
  // one of its two factors is a top (sign) bit.
  for (genvar r = 0; r < NR; r++) begin : g_row
    for (genvar k = 0; k < PW; k++) begin : g_bit
      localparam int J   = k - r;
      localparam bit INV = ((r == NR - 1) != (J == NR - 1));
      if (J >= 0 && J < NR) begin : g_term
        assign rows_o[r][k] = (ax[J] & bx[r]) ^ INV;
      end else begin : g_zero
        assign rows_o[r][k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/oem_csa_chain.sv
module oem_csa_chain #(
  parameter int PW   = 32,
  parameter int NADD = 7
) (
  input  logic [PW-1:0]            s_i,
  input  logic [PW-1:0]            c_i,
  input  logic [NADD-1:0][PW-1:0]  add_i,
  output logic [PW-1:0]            s_o,
  output logic [PW-1:0]            c_o
);

  logic [NADD:0][PW-1:0] s_st;
  logic [NADD:0][PW-1:0] c_st;

  assign s_st[0] = s_i;
  assign c_st[0] = c_i;

  // One full-adder row per added vector; the carry vector moves one column up.
  for (genvar g = 0; g < NADD; g++) begin : g_stage
    logic [PW-1:0] maj;
    assign maj         = (s_st[g] & c_st[g]) | (s_st[g] & add_i[g]) | (c_st[g] & add_i[g]);
    assign s_st[g + 1] = s_st[g] ^ c_st[g] ^ add_i[g];
    assign c_st[g + 1] = maj << 1;
  end

  assign s_o = s_st[NADD];
  assign c_o = c_st[NADD];

endmodule

// File: rtl/oem_merge.sv
module oem_merge #(
  parameter int PW = 32
) (
  input  logic [PW-1:0] ev_s_i,
  input  logic [PW-1:0] ev_c_i,
  input  logic [PW-1:0] od_s_i,
  input  logic [PW-1:0] od_c_i,
  output logic [PW-1:0] p_o
);

  logic [PW-1:0] t_s, t_maj, t_c;
  logic [PW-1:0] u_s, u_maj, u_c;

  // 4:2 compression as two full-adder rows.
  assign t_s   = ev_s_i ^ ev_c_i ^ od_s_i;
  assign t_maj = (ev_s_i & ev_c_i) | (ev_s_i & od_s_i) | (ev_c_i & od_s_i);
  assign t_c   = t_maj << 1;

  assign u_s   = t_s ^ t_c ^ od_c_i;
  assign u_maj = (t_s & t_c) | (t_s & od_c_i) | (t_c & od_c_i);
  assign u_c   = u_maj << 1;

  // Final carry-propagate addition, wrapping at PW bits.
  assign p_o = u_s + u_c;

endmodule

// File: rtl/oem_core.sv
module oem_core
  import oem_pkg::*;
#(
  parameter  int OPW = 16,
  localparam int PW  = 2 * OPW
) (
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic           a_sgn_i,
  input  logic           b_sgn_i,
  output logic [PW-1:0]  p_o,
  output logic [PW-1:0]  ev_s_o,
  output logic [PW-1:0]  ev_c_o,
  output logic [PW-1:0]  od_s_o,
  output logic [PW-1:0]  od_c_o
);

  localparam int NR  = OPW + 1;
  localparam int NE  = even_row_count(NR);
  localparam int NO  = odd_row_count(NR);
  localparam int NEA = NE - 2;   // rows added after the even chain's first two
  localparam int NOA = NO - 1;   // rows added after the odd chain's first row
  // Sign-inversion correction, reduced modulo 2^PW.
  localparam logic [PW-1:0] CORR = PW'(1) << NR;

  logic [NR-1:0][PW-1:0]  rows;
  logic [NEA-1:0][PW-1:0] ev_add;
  logic [NOA-1:0][PW-1:0] od_add;

  oem_ppgen #(.OPW(OPW)) u_ppgen (
    .a_i     (a_i),
    .b_i     (b_i),
    .a_sgn_i (a_sgn_i),
    .b_sgn_i (b_sgn_i),
    .rows_o  (rows)
  );

  for (genvar k = 0; k < NEA; k++) begin : g_ev
    assign ev_add[k] = rows[2 * k + 4];
  end
  for (genvar k = 0; k < NOA; k++) begin : g_od
    assign od_add[k] = rows[2 * k + 3];
  end

  // Chain of rows 0, 2, 4, ...
  oem_csa_chain #(.PW(PW), .NADD(NEA)) u_even (
    .s_i   (rows[0]),
    .c_i   (rows[2]),
    .add_i (ev_add),
    .s_o   (ev_s_o),
    .c_o   (ev_c_o)
  );

  // Chain of rows 1, 3, 5, ..., seeded with the correction constant.
  oem_csa_chain #(.PW(PW), .NADD(NOA)) u_odd (
    .s_i   (rows[1]),
    .c_i   (CORR),
    .add_i (od_add),
    .s_o   (od_s_o),
    .c_o   (od_c_o)
  );

  oem_merge #(.PW(PW)) u_merge (
    .ev_s_i (ev_s_o),
    .ev_c_i (ev_c_o),
    .od_s_i (od_s_o),
    .od_c_i (od_c_o),
    .p_o    (p_o)
  );

endmodule

// File: rtl/oem_stage.sv
module oem_stage #(
  parameter int W  = 8,
  parameter int EN = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (EN != 0) begin : g_reg
    logic [W-1:0] q_nxt;
    logic [W-1:0] q_r;

    always_comb begin
      q_nxt = q_r;
      if (ld) q_nxt = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= q_nxt;
    end

    assign q = q_r;
  end else begin : g_wire
    logic unused_ok;
    assign unused_ok = ^{clk, rst_n, ld};
    assign q = d;
  end

endmodule

// File: rtl/oem_mult.sv
module oem_mult #(
  parameter int OPW     = 16,
  parameter int IN_REG  = 1,
  parameter int OUT_REG = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [OPW-1:0]     opd_a,
  input  logic [OPW-1:0]     opd_b,
  input  logic               a_signed,
  input  logic               b_signed,
  output logic               out_valid,
  output logic [2*OPW-1:0]   product
);

  localparam int PW = 2 * OPW;
  localparam int BW = 2 * OPW + 2;

  logic [BW-1:0]  in_bus;
  logic [BW-1:0]  reg_bus;
  logic [OPW-1:0] core_a;
  logic [OPW-1:0] core_b;
  logic           core_as;
  logic           core_bs;
  logic           mid_valid;
  logic [PW-1:0]  core_p;
  logic [PW-1:0]  ev_s, ev_c, od_s, od_c;

  assign in_bus = {a_signed, b_signed, opd_a, opd_b};

  oem_stage #(.W(BW), .EN(IN_REG)) u_in_data (
    .clk (clk), .rst_n (rst_n), .ld (in_valid), .d (in_bus), .q (reg_bus)
  );

  oem_stage #(.W(1), .EN(IN_REG)) u_in_vld (
    .clk (clk), .rst_n (rst_n), .ld (1'b1), .d (in_valid), .q (mid_valid)
  );

  assign {core_as, core_bs, core_a, core_b} = reg_bus;

  oem_core #(.OPW(OPW)) u_core (
    .a_i     (core_a),
    .b_i     (core_b),
    .a_sgn_i (core_as),
    .b_sgn_i (core_bs),
    .p_o     (core_p),
    .ev_s_o  (ev_s),
    .ev_c_o  (ev_c),
    .od_s_o  (od_s),
    .od_c_o  (od_c)
  );

  oem_stage #(.W(PW), .EN(OUT_REG)) u_out_data (
    .clk (clk), .rst_n (rst_n), .ld (mid_valid), .d (core_p), .q (product)
  );

  oem_stage #(.W(1), .EN(OUT_REG)) u_out_vld (
    .clk (clk), .rst_n (rst_n), .ld (1'b1), .d (mid_valid), .q (out_valid)
  );

endmodule

// File: rtl/oem_mult_chk.sv
module oem_mult_chk #(
  parameter  int OPW     = 16,
  parameter  int IN_REG  = 1,
  parameter  int OUT_REG = 1,
  localparam int PW      = 2 * OPW
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           mid_valid,
  input logic           out_valid,
  input logic [PW-1:0]  product,
  input logic [OPW-1:0] core_a,
  input logic [OPW-1:0] core_b,
  input logic           core_as,
  input logic           core_bs,
  input logic [PW-1:0]  core_p,
  input logic [PW-1:0]  ev_s,
  input logic [PW-1:0]  ev_c,
  input logic [PW-1:0]  od_s,
  input logic [PW-1:0]  od_c
);

  logic signed [OPW:0]    xa, xb;
  logic signed [PW+1:0]   full;
  logic [PW-1:0]          ref_p;

  assign xa    = $signed({core_as & core_a[OPW-1], core_a});
  assign xb    = $signed({core_bs & core_b[OPW-1], core_b});
  assign full  = (PW+2)'(xa) * (PW+2)'(xb);
  assign ref_p = PW'(full);

  // R1, R2, R3, R4: core result equals the behavioural product in every mode
  a_r1_core_ref: assert property (@(posedge clk) disable iff (!rst_n)
    core_p == ref_p);

  // R8: the two chain pairs together carry the whole product
  a_r8_merge_sum: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(ev_s + ev_c + od_s + od_c) == core_p);

  if (IN_REG != 0) begin : g_in
    a_r5_in_stage: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> mid_valid);
    a_r5_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !mid_valid);
  end

  if (OUT_REG != 0) begin : g_out
    a_r5_out_stage: assert property (@(posedge clk) disable iff (!rst_n)
      mid_valid |=> out_valid);
    a_r5_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mid_valid |=> !out_valid);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mid_valid |=> $stable(product));
  end

endmodule

bind oem_mult oem_mult_chk #(.OPW(OPW), .IN_REG(IN_REG), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mid_valid (mid_valid),
  .out_valid (out_valid),
  .product   (product),
  .core_a    (core_a),
  .core_b    (core_b),
  .core_as   (core_as),
  .core_bs   (core_bs),
  .core_p    (core_p),
  .ev_s      (ev_s),
  .ev_c      (ev_c),
  .od_s      (od_s),
  .od_c      (od_c)
);

// File: tb/oem_mult_tb.sv
module oem_mult_tb;

  localparam int OPW = 16;
  localparam int PW  = 32;
  localparam int LAT = 2;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [OPW-1:0] opd_a, opd_b;
  logic           a_signed, b_signed;
  logic           out_valid;
  logic [PW-1:0]  product;

  oem_mult #(.OPW(OPW), .IN_REG(1), .OUT_REG(1)) u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .opd_a (opd_a), .opd_b (opd_b), .a_signed (a_signed), .b_signed (b_signed),
    .out_valid (out_valid), .product (product)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [PW-1:0] p;
    int            stamp;
    string         tag;
  } item_t;

  item_t         sbq[$];
  int            checks = 0, errors = 0;
  int            pushed = 0, popped = 0;
  bit            mon_on = 0, have_last = 0, done = 0;
  logic [PW-1:0] last_p;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] ref_mul(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                                             input logic sa, input logic sb);
    longint x, y;
    x = sa ? longint'($signed(a)) : longint'(a);
    y = sb ? longint'($signed(b)) : longint'(b);
    return PW'(x * y);
  endfunction

  function automatic string mode_tag(input logic sa, input logic sb);
    if (sa && sb)   return "R2";
    if (!sa && !sb) return "R1";
    return "R3";
  endfunction

  task automatic push_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                         input logic sa, input logic sb, input string tag);
    item_t it;
    @(negedge clk);
    opd_a = a; opd_b = b; a_signed = sa; b_signed = sb; in_valid = 1'b1;
    it.p = ref_mul(a, b, sa, sb);
    it.stamp = cyc;
    it.tag = tag;
    sbq.push_back(it);
    pushed++;
  endtask

  // Idle cycles carry random operand data that must be ignored (R6).
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      opd_a = OPW'($urandom); opd_b = OPW'($urandom);
      a_signed = 1'($urandom); b_signed = 1'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pop and compare as results appear.
  always @(negedge clk) begin : mon
    item_t it;
    if (rst_n && mon_on) begin
      if (out_valid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R5", "result without issued operation", product, '0);
        end else begin
          it = sbq.pop_front();
          popped++;
          // R8: the split array plus merge gives the exact product
          check(product == it.p, it.tag, "product", product, it.p);
          check(cyc - it.stamp == LAT, "R5", "latency", PW'(cyc - it.stamp), PW'(LAT));
          last_p = product;
          have_last = 1;
        end
      end else if (have_last) begin
        check(product == last_p, "R6", "hold while idle", product, last_p);
      end
    end
  end

  initial begin
    #(200000 * 10);
    check(1'b0, "R9", "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    logic [OPW-1:0] cv [5];
    cv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF};
    in_valid = 0; opd_a = '0; opd_b = '0; a_signed = 0; b_signed = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", PW'(out_valid), '0);
    check(product == '0, "R7", "product in reset", product, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid after reset", PW'(out_valid), '0);
    check(product == '0, "R7", "product after reset", product, '0);
    mon_on = 1;

    // Directed mode checks
    push_op(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R1");
    push_op(16'h8000, 16'h8000, 1'b1, 1'b1, "R2");
    push_op(16'hFFFF, 16'h0002, 1'b1, 1'b0, "R3");
    push_op(16'h0002, 16'hFFFF, 1'b0, 1'b1, "R3");
    idle(4);

    // R4 corners in every mode, issued back to back (R9)
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          push_op(cv[i], cv[j], m[1], m[0], "R4");
    idle(3);

    // Random stream with random gaps
    for (int n = 0; n < 1500; n++) begin
      logic sa, sb;
      sa = 1'($urandom); sb = 1'($urandom);
      push_op(OPW'($urandom), OPW'($urandom), sa, sb, mode_tag(sa, sb));
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
    end
    idle(6);

    // R9: every issued operation produced exactly one result
    check(sbq.size() == 0, "R9", "results outstanding", PW'(sbq.size()), '0);
    check(pushed == popped, "R9", "issued vs returned", PW'(popped), PW'(pushed));
    finish_run();
  end

endmodule